// File: doc/BRIEF.md
# Infrared Transmit Pulse Sequencer

This block drives an infrared LED from a queue of timed segments. Software writes segment commands into a 64-entry queue. Each command sets a duration and says whether the LED carries a carrier or stays dark for that time. Once transmission is enabled, the sequencer takes commands from the queue one after another, with no gap between them. It times each one with a 10-bit counter. Each command selects its own time unit, so a single queue can hold both short carrier bursts and long pauses.

A carrier generator produces the modulation. It has a programmable high length and a programmable low length, and it counts ticks from a source that software selects. The generator restarts in its high phase at the start of every segment. The LED output is the carrier gated by the current segment. When the queue runs dry, the output returns to dark and the busy indication drops in the same cycle. A synchronous block clear empties the queue and stops any segment in progress.

Top module: `irtx_seq`

## Requirements
- R1: Writing the command address (wr_addr = 2) with wr_data bit 16 set appends wr_data[12:0] to the queue. A command-address write with bit 16 clear queues nothing, and fifo_empty stays 1.
- R2: A command holds its count in bits [9:0]. Its segment lasts count+1 time units, and the next queued command starts in the cycle after the last unit, with no gap.
- R3: Command bits [11:10] select the time unit: 0 counts tick_1us pulses, 1 counts tick_10us pulses, 2 counts tick_100us pulses, 3 counts completed carrier periods.
- R4: The carrier word (wr_addr = 1) holds the high length minus one in bits [31:16] and the low length minus one in bits [15:0], both in carrier ticks. In a segment with command bit 12 set, ir_out repeats high for the high length and then low for the low length. In a segment with bit 12 clear, ir_out stays 0.
- R5: The carrier restarts in its high phase in the first cycle of every segment, whatever phase the previous segment ended in.
- R6: Control bits [13:12] (wr_addr = 0) select the carrier tick: 0 every clock cycle, 1 tick_xtal, 2 tick_1us, 3 tick_10us. If the selected tick never arrives, the carrier stays in its high phase.
- R7: Control bit 0 enables transmission. While it is 0, no new segment starts and queued commands are kept.
- R8: While control bit 2 is 1, ir_out is 1.
- R9: The queue holds 64 commands. A push while the queue is full is dropped and sets overflow, which stays 1 until reset or soft_rst.
- R10: When a segment ends with the queue empty, busy and ir_out both go to 0 in the next cycle and fifo_empty reads 1.
- R11: A one-cycle soft_rst pulse empties the queue, ends any segment and clears overflow. Control and carrier settings are kept.
- R12: After reset, busy = 0, fifo_empty = 1, ir_out = 0 and overflow = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| soft_rst | input | 1 | Synchronous block clear of the queue, the timers and overflow |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 carrier, 2 command |
| wr_data | input | 32 | Register write data |
| tick_xtal | input | 1 | One-cycle crystal-derived tick |
| tick_1us | input | 1 | One-cycle microsecond tick |
| tick_10us | input | 1 | One-cycle 10 us tick |
| tick_100us | input | 1 | One-cycle 100 us tick |
| ir_out | output | 1 | LED drive |
| fifo_empty | output | 1 | Command queue is empty |
| busy | output | 1 | A segment is being output |
| overflow | output | 1 | Sticky flag for a dropped push |

## Verification
The hardest case to reach from the ports is a drain with no gaps: one segment ends in the same cycle that the next one loads, while the carrier is partway through a period. To hold every command until the whole batch is queued, the bench loads each batch with transmission disabled and then enables it. The carrier tick is held at every clock, so the expected waveform is exact to the cycle, and a scoreboard compares ir_out and busy in every cycle until the final idle cycle. For the 64-entry bound, the bench pushes 65 commands and then checks that busy lasts exactly 64 one-cycle segments.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

    localparam int CNT_W   = 10;
    localparam int CAR_W   = 16;
    localparam int CMD_W   = CNT_W + 3;
    localparam int PUSH_BIT = 16;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CAR  = 2'd1;
    localparam logic [1:0] ADDR_CMD  = 2'd2;

    typedef enum logic [1:0] {
        UNIT_1US     = 2'd0,
        UNIT_10US    = 2'd1,
        UNIT_100US   = 2'd2,
        UNIT_CARRIER = 2'd3
    } unit_sel_t;

    typedef enum logic [1:0] {
        CSRC_CLK   = 2'd0,
        CSRC_XTAL  = 2'd1,
        CSRC_1US   = 2'd2,
        CSRC_10US  = 2'd3
    } car_src_t;

    typedef struct packed {
        logic             modulate;
        unit_sel_t        unit;
        logic [CNT_W-1:0] count;
    } seg_cmd_t;

    typedef struct packed {
        car_src_t src;
        logic     init_high;
        logic     enable;
    } ctrl_t;

    function automatic logic pick_tick(input logic [1:0] sel, input logic [3:0] ticks);
        return ticks[sel];
    endfunction

endpackage

// File: rtl/irtx_fifo.sv
module irtx_fifo
    import irtx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  logic     pop,
    input  seg_cmd_t din,
    output seg_cmd_t dout,
    output logic     empty,
    output logic     full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    seg_cmd_t       store [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  level;
    logic           push_ok, pop_ok;

    assign empty   = (level == '0);
    assign full    = (level == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = store[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) store[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> full); // R9

endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier
    import irtx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic             tick,
    input  logic [CAR_W-1:0] high_m1,
    input  logic [CAR_W-1:0] low_m1,
    output logic             phase_high,
    output logic             period_done
);
    logic [CAR_W-1:0] phase_cnt;
    logic             advance;

    assign advance     = run && tick;
    assign period_done = advance && !phase_high && (phase_cnt == low_m1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_high <= 1'b1;
            phase_cnt  <= '0;
        end else if (advance) begin
            if (phase_high) begin
                if (phase_cnt == high_m1) begin
                    phase_high <= 1'b0;
                    phase_cnt  <= '0;
                end else begin
                    phase_cnt <= phase_cnt + 1'b1;
                end
            end else begin
                if (phase_cnt == low_m1) begin
                    phase_high <= 1'b1;
                    phase_cnt  <= '0;
                end else begin
                    phase_cnt <= phase_cnt + 1'b1;
                end
            end
        end
    end

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart |=> (phase_high && phase_cnt == '0)); // R5

endmodule

// File: rtl/irtx_segment.sv
module irtx_segment
    import irtx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     q_empty,
    input  seg_cmd_t q_head,
    input  logic     tick_1us,
    input  logic     tick_10us,
    input  logic     tick_100us,
    input  logic     car_period,
    output logic     pop,
    output logic     active,
    output logic     modulate
);
    seg_cmd_t         cur;
    logic [CNT_W-1:0] units;
    logic             unit_tick;
    logic             seg_end;

    assign unit_tick = pick_tick(cur.unit, {car_period, tick_100us, tick_10us, tick_1us});
    assign seg_end   = active && unit_tick && (units == cur.count);
    assign pop       = enable && !q_empty && (!active || seg_end);
    assign modulate  = cur.modulate;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            units  <= '0;
            cur    <= '0;
        end else if (pop) begin
            active <= 1'b1;
            units  <= '0;
            cur    <= q_head;
        end else if (seg_end) begin
            active <= 1'b0;
        end else if (active && unit_tick) begin
            units <= units + 1'b1;
        end
    end

    AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (seg_end && q_empty) |=> !active); // R10
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!enable && !active) |=> !active); // R7

endmodule

// File: rtl/irtx_seq.sv
module irtx_seq
    import irtx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        soft_rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        tick_xtal,
    input  logic        tick_1us,
    input  logic        tick_10us,
    input  logic        tick_100us,
    output logic        ir_out,
    output logic        fifo_empty,
    output logic        busy,
    output logic        overflow
);
    localparam logic [CAR_W-1:0] CAR_RESET_M1 = CAR_W'(12);

    ctrl_t            ctrl;
    logic [CAR_W-1:0] car_high_m1, car_low_m1;
    logic             clr;
    logic             push, pop, q_full, active, seg_mod;
    logic             car_tick, car_high, car_period;
    seg_cmd_t         q_head;
    logic             unused_bits;

    assign clr  = rst || soft_rst;
    assign push = wr_en && (wr_addr == ADDR_CMD) && wr_data[PUSH_BIT];
    assign unused_bits = ^{wr_data[31:17], wr_data[15:14], wr_data[11:3], wr_data[1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl        <= '0;
            car_high_m1 <= CAR_RESET_M1;
            car_low_m1  <= CAR_RESET_M1;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL) begin
                ctrl.enable    <= wr_data[0];
                ctrl.init_high <= wr_data[2];
                ctrl.src       <= car_src_t'(wr_data[13:12]);
            end
            if (wr_addr == ADDR_CAR) begin
                car_high_m1 <= wr_data[31:16];
                car_low_m1  <= wr_data[15:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr)                 overflow <= 1'b0;
        else if (push && q_full) overflow <= 1'b1;
    end

    assign car_tick = pick_tick(ctrl.src, {tick_10us, tick_1us, tick_xtal, 1'b1});

    irtx_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk   (clk),
        .rst   (clr),
        .push  (push),
        .pop   (pop),
        .din   (seg_cmd_t'(wr_data[CMD_W-1:0])),
        .dout  (q_head),
        .empty (fifo_empty),
        .full  (q_full)
    );

    irtx_segment i_segment (
        .clk        (clk),
        .rst        (clr),
        .enable     (ctrl.enable),
        .q_empty    (fifo_empty),
        .q_head     (q_head),
        .tick_1us   (tick_1us),
        .tick_10us  (tick_10us),
        .tick_100us (tick_100us),
        .car_period (car_period),
        .pop        (pop),
        .active     (active),
        .modulate   (seg_mod)
    );

    irtx_carrier i_carrier (
        .clk         (clk),
        .rst         (clr),
        .restart     (pop),
        .run         (active),
        .tick        (car_tick),
        .high_m1     (car_high_m1),
        .low_m1      (car_low_m1),
        .phase_high  (car_high),
        .period_done (car_period)
    );

    assign busy   = active;
    assign ir_out = ctrl.init_high || (active && seg_mod && car_high);

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ctrl.init_high) |-> !ir_out); // R10
    AST_INIT_HIGH: assert property (@(posedge clk) disable iff (rst)
        ctrl.init_high |-> ir_out); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overflow && !soft_rst) |=> overflow); // R9

endmodule

// File: tb/test_irtx_seq.sv
`timescale 1ns/1ps
module test_irtx_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        tick_xtal, tick_1us, tick_10us, tick_100us;
    logic        ir_out, fifo_empty, busy, overflow;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic exp_q[$];

    always #2.5 clk = ~clk;

    irtx_seq i_irtx_seq (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tick_xtal(tick_xtal), .tick_1us(tick_1us),
        .tick_10us(tick_10us), .tick_100us(tick_100us),
        .ir_out(ir_out), .fifo_empty(fifo_empty),
        .busy(busy), .overflow(overflow)
    );

    initial begin
        int ph = 0;
        tick_xtal = 1'b0; tick_1us = 1'b1; tick_10us = 1'b0; tick_100us = 1'b0;
        forever begin
            @(posedge clk); #1;
            ph++;
            tick_10us  = (ph % 3 == 0);
            tick_100us = (ph % 5 == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // driver: queue one command and its expected per-cycle output
    task automatic push_cmd(input bit md, input int unit, input int cnt,
                            input int hi, input int lo, input bit frozen, input bit keep);
        int len;
        wr(2'd2, 32'h1_0000 | (32'(md) << 12) | (32'(unit) << 10) | 32'(cnt));
        if (keep) begin
            len = (unit == 3) ? (cnt + 1) * (hi + lo) : cnt + 1;
            for (int k = 0; k < len; k++)
                exp_q.push_back(md && (frozen || ((k % (hi + lo)) < hi)));
        end
    endtask

    // monitor: compare each busy cycle against the scoreboard
    task automatic drain(input string req);
        int w = 0;
        while (!busy && w < 200) begin @(negedge clk); w++; end
        chk(busy, req, busy, 1);
        while (exp_q.size() > 0) begin
            logic e;
            e = exp_q.pop_front();
            chk(busy === 1'b1 && ir_out === e, req, {busy, ir_out}, {1'b1, e});
            @(negedge clk);
        end
        chk(!busy && !ir_out, {req, " R10 idle"}, {busy, ir_out}, 0);
        chk(fifo_empty, {req, " R10 empty"}, fifo_empty, 1);
    endtask

    task automatic count_ticks(input int which, input int exp, input string req);
        int n = 0;
        int w = 0;
        while (!busy && w < 200) begin @(negedge clk); w++; end
        while (busy && w < 5000) begin
            if ((which == 1 && tick_10us) || (which == 2 && tick_100us)) n++;
            @(negedge clk); w++;
        end
        chk(n == exp, req, n, exp);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(!busy && fifo_empty && !ir_out && !overflow, "R12",
            {busy, fifo_empty, ir_out, overflow}, 4'b0100);

        // R1 command write without the push bit
        wr(2'd2, 32'h0000_1005);
        @(negedge clk);
        chk(fifo_empty, "R1 no push", fifo_empty, 1);

        // R2 R4 R5 R7 carrier 3 high / 2 low, every clock
        wr(2'd1, {16'd2, 16'd1});
        wr(2'd0, 32'h0);
        push_cmd(1, 0, 9, 3, 2, 0, 1);
        push_cmd(0, 0, 4, 3, 2, 0, 1);
        push_cmd(1, 0, 5, 3, 2, 0, 1);
        push_cmd(1, 0, 1, 3, 2, 0, 1);
        repeat (5) @(negedge clk);
        chk(!busy && !fifo_empty, "R7 hold", {busy, fifo_empty}, 2'b00);
        wr(2'd0, 32'h1);
        drain("R2 R4 R5");

        // R3 unit = carrier period, 2 high / 2 low
        wr(2'd0, 32'h0);
        wr(2'd1, {16'd1, 16'd1});
        push_cmd(1, 3, 1, 2, 2, 0, 1);
        push_cmd(0, 3, 2, 2, 2, 0, 1);
        wr(2'd0, 32'h1);
        drain("R3 carrier unit");

        // R6 tick_xtal never pulses: carrier frozen high
        wr(2'd0, 32'h0);
        push_cmd(1, 0, 4, 2, 2, 1, 1);
        wr(2'd0, 32'h1 | (32'd1 << 12));
        drain("R6 xtal source");
        wr(2'd0, 32'h0);
        push_cmd(1, 0, 5, 2, 2, 0, 1);
        wr(2'd0, 32'h1 | (32'd2 << 12));
        drain("R6 1us source");

        // R3 10 us and 100 us units
        wr(2'd0, 32'h0);
        push_cmd(0, 1, 3, 1, 1, 0, 0);
        wr(2'd0, 32'h1);
        count_ticks(1, 4, "R3 10us unit");
        wr(2'd0, 32'h0);
        push_cmd(0, 2, 2, 1, 1, 0, 0);
        wr(2'd0, 32'h1);
        count_ticks(2, 3, "R3 100us unit");

        // R8 forced high
        wr(2'd0, 32'h4);
        @(negedge clk);
        chk(ir_out, "R8 forced", ir_out, 1);
        wr(2'd0, 32'h0);
        @(negedge clk);
        chk(!ir_out, "R8 released", ir_out, 0);

        // R9 capacity and overflow
        for (int i = 0; i < 65; i++) push_cmd(0, 0, 0, 1, 1, 0, i < 64);
        @(negedge clk);
        chk(overflow, "R9 overflow", overflow, 1);
        wr(2'd0, 32'h1);
        drain("R9 depth");
        chk(overflow, "R9 sticky", overflow, 1);

        // R11 soft clear
        wr(2'd0, 32'h0);
        for (int i = 0; i < 3; i++) push_cmd(1, 0, 7, 1, 1, 0, 0);
        @(negedge clk);
        chk(!fifo_empty, "R11 loaded", fifo_empty, 0);
        @(posedge clk); #1 soft_rst = 1'b1;
        @(posedge clk); #1 soft_rst = 1'b0;
        @(negedge clk);
        chk(fifo_empty && !overflow && !busy && !ir_out, "R11 cleared",
            {fifo_empty, overflow, busy, ir_out}, 4'b1000);
        wr(2'd0, 32'h1);
        repeat (10) @(negedge clk);
        chk(!busy, "R11 nothing left", busy, 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule